// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block takes a single-data-rate SDRAM from power-up to normal operation and then keeps it refreshed. When a start request arrives it drives a fixed command sequence on the chip-select, row-strobe, column-strobe, write-enable, address and bank pins: a precharge of all banks, a run of auto (CBR) refreshes, and a write of the supplied value into the device's mode register. A fixed number of NOP cycles separates consecutive commands. This covers the precharge and refresh recovery times.

Once the mode write and its recovery gap are both complete, the block raises its init-done flag and moves to normal mode. In normal mode a two-stage timer, made of a prescaler and a refresh count, fires one auto refresh each time it runs out and then reloads. Data paths, bank management for ordinary accesses and arbitration with user traffic belong to other blocks.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, and afterwards until a start request is sampled, the command pins show deselect: {cs_n,ras_n,cas_n,we_n} = 4'b1111. During this time init_done is 0 and addr and ba are 0.
- R2: One cycle after start is sampled in idle, the pins carry a precharge-all command (4'b0010) with addr bit 10 set, all other address bits 0 and ba 0.
- R3: After the precharge, INIT_REFS (8) auto refresh commands (4'b0001) follow. Each command comes GAP+1 cycles after the one before it.
- R4: GAP+1 cycles after the last initial refresh, a mode register write (4'b0000) appears with addr equal to mode_val and ba equal to 0.
- R5: init_done rises exactly GAP+1 cycles after the mode register write. It then stays high until reset, and no precharge or mode write is issued while it is high.
- R6: In normal mode an auto refresh is issued every (presc+1)*(rcount+1) cycles. The first one comes that many cycles after init_done rises, and no other command is issued in normal mode.
- R7: A start request sampled while the sequence is running, or in normal mode, has no effect on the command stream.
- R8: Every cycle between commands, once the sequence has started, is a NOP: 4'b0111 with addr and ba both 0.
- R9: Asserting reset at any point, including normal mode, returns the block to the R1 idle state. It stays there until a new start request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin the power-up sequence |
| mode_val | input | ADDR_W | Value written to the mode register |
| presc | input | PRE_W | Prescaler reload value (period is presc+1 cycles) |
| rcount | input | CNT_W | Refresh count reload value (period is rcount+1 prescaler ticks) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins, with bit 10 used as the all-banks flag |
| ba | output | BANK_W | Bank select |
| init_done | output | 1 | High once the device is in normal mode |

## Verification
The bench builds the block with GAP=2, INIT_REFS=8, a 13-bit address and 4-bit prescaler and refresh count. With these values the whole initial sequence fits in 30 cycles. The refresh period can be swept over every prescaler and count value from 0 to 3, so it can be checked cycle by cycle against an arithmetic model for all sixteen combinations. Spurious start pulses are injected mid-sequence and in normal mode, and reset is applied from normal mode.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int ADDR_W    = 13,
  parameter int BANK_W    = 2,
  parameter int PRE_W     = 8,
  parameter int CNT_W     = 8,
  parameter int GAP       = 2,
  parameter int INIT_REFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] mode_val,
  input  logic [PRE_W-1:0]  presc,
  input  logic [CNT_W-1:0]  rcount,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              init_done
);

  localparam int GW = $clog2(GAP + 2);
  localparam int SW = $clog2(INIT_REFS + 2);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  localparam logic [3:0] C_DESEL = 4'b1111;
  localparam logic [3:0] C_NOP   = 4'b0111;
  localparam logic [3:0] C_PRE   = 4'b0010;
  localparam logic [3:0] C_REF   = 4'b0001;
  localparam logic [3:0] C_MRS   = 4'b0000;

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_NORM} st_t;

  st_t              st;
  logic [3:0]       cmd;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] ba_q;
  logic [GW-1:0]    wait_q;
  logic [SW-1:0]    step;
  logic [PRE_W-1:0] pc;
  logic [CNT_W-1:0] rc;
  logic             done_q;

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign addr      = addr_q;
  assign ba        = ba_q;
  assign init_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cmd    <= C_DESEL;
      addr_q <= '0;
      ba_q   <= '0;
      wait_q <= '0;
      step   <= '0;
      pc     <= '0;
      rc     <= '0;
      done_q <= 1'b0;
    end else begin
      cmd    <= C_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      case (st)
        S_IDLE: begin
          cmd <= C_DESEL;
          if (start) begin
            cmd    <= C_PRE;
            addr_q <= ALL_BANKS;
            st     <= S_INIT;
            wait_q <= GW'(GAP);
            step   <= '0;
          end
        end
        S_INIT: begin
          if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
          end else begin
            wait_q <= GW'(GAP);
            step   <= step + 1'b1;
            if (step < SW'(INIT_REFS)) begin
              cmd <= C_REF;
            end else if (step == SW'(INIT_REFS)) begin
              cmd    <= C_MRS;
              addr_q <= mode_val;
            end else begin
              st     <= S_NORM;
              done_q <= 1'b1;
              pc     <= presc;
              rc     <= rcount;
            end
          end
        end
        S_NORM: begin
          if (pc != '0) begin
            pc <= pc - 1'b1;
          end else begin
            pc <= presc;
            if (rc != '0) begin
              rc <= rc - 1'b1;
            end else begin
              rc  <= rcount;
              cmd <= C_REF;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module sdram_init_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] ba,
  input logic              init_done
);
  logic [3:0] c;
  assign c = {cs_n, ras_n, cas_n, we_n};

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b1111 && !start) |=> (c == 4'b1111 && !init_done));

  a_r2_start_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b1111 && start) |=> (c == 4'b0010));

  a_r2_precharge_a10: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0010) |-> addr[10]);

  a_r4_mrs_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0000) |-> (ba == '0));

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r5_done_cmds: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (c == 4'b0111 || c == 4'b0001));

  a_r8_gap_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (c[3] == 1'b0 && c != 4'b0111 && !init_done) |=> (c == 4'b0111));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .init_done(init_done)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
  localparam int AW = 13, BW = 2, PW = 4, CW = 4, G = 2, NR = 8;
  localparam int DONE_AT = (NR + 2) * (G + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] mode_val = '0;
  logic [PW-1:0] presc = '0;
  logic [CW-1:0] rcount = '0;
  logic cs_n, ras_n, cas_n, we_n, init_done;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(.ADDR_W(AW), .BANK_W(BW), .PRE_W(PW), .CNT_W(CW), .GAP(G), .INIT_REFS(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_val(mode_val), .presc(presc),
    .rcount(rcount), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done));

  task automatic chk(string tag, logic [3:0] ec, logic [AW-1:0] ea, logic ed);
    total++;
    if ({cs_n, ras_n, cas_n, we_n} !== ec || addr !== ea || ba !== '0 || init_done !== ed) begin
      bad++;
      $display("FAIL %s: cmd=%b addr=%h ba=%h done=%b expected cmd=%b addr=%h ba=0 done=%b",
               tag, {cs_n, ras_n, cas_n, we_n}, addr, ba, init_done, ec, ea, ed);
    end
  endtask

  task automatic idle_check(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      chk(tag, 4'b1111, '0, 1'b0);
    end
  endtask

  task automatic run_cfg(int p, int r, logic [AW-1:0] mv, bit spur);
    int per, last, s1, s2;
    per = (p + 1) * (r + 1);
    last = DONE_AT + 3 * per + 2;
    s1 = 5; s2 = DONE_AT + 1;
    @(negedge clk);
    rst_n = 0; presc = PW'(p); rcount = CW'(r); mode_val = mv;
    @(posedge clk); @(negedge clk);
    chk("R1 reset", 4'b1111, '0, 1'b0);
    rst_n = 1;
    idle_check("R1 idle", 3);
    for (int j = 0; j <= last; j++) begin
      logic [3:0] ec;
      logic [AW-1:0] ea;
      string tag;
      start = (j == 0) || (spur && (j == s1 || j == s2));
      @(posedge clk); @(negedge clk);
      start = 0;
      ec = 4'b0111; ea = '0; tag = "R8 nop";
      if (j == 0) begin ec = 4'b0010; ea = AW'(1) << 10; tag = "R2 precharge"; end
      else if (j % (G + 1) == 0 && j / (G + 1) <= NR) begin ec = 4'b0001; tag = "R3 init refresh"; end
      else if (j == (NR + 1) * (G + 1)) begin ec = 4'b0000; ea = mv; tag = "R4 mode write"; end
      else if (j == DONE_AT) tag = "R5 done";
      else if (j > DONE_AT) begin
        tag = "R6 periodic";
        if ((j - DONE_AT) % per == 0) ec = 4'b0001;
      end
      if (spur && (j == s1 + 1 || j == s2 + 1)) tag = "R7 start ignored";
      chk(tag, ec, ea, j >= DONE_AT);
    end
    @(negedge clk);
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    chk("R9 reset from normal", 4'b1111, '0, 1'b0);
    rst_n = 1;
    idle_check("R9 idle after reset", 4);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++)
        run_cfg(p, r, AW'(13'h0A5 + p * 97 + r * 1031), (p + r) % 2 == 1);
    run_cfg(3, 3, '1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule